// File: doc/BRIEF.md
# 72/64 SEC-DED Check-Byte Corrector

This block protects 64-bit words with an 8-bit check byte. It has two paths. The encoder path computes the check byte for a data word. The corrector path receives a stored data word and its stored check byte. It forms the syndrome, repairs any single flipped bit in either the data or the check byte, and reports a status.

The check matrix is fixed. Its eight rows are byte rotations of one 64-bit pattern. A syndrome is decoded by comparing it against the 64 matrix columns. Any syndrome that is not zero, not a single check bit and not a data column is reported as uncorrectable, and the inputs pass through untouched.

A parameter selects a purely combinational corrector or one register stage on its outputs. The encoder path is always combinational.

Top module: `ecc72_corrector`

## Requirements
- R1: Check bit i (0..7) is the even parity of the data word ANDed with row i. Row i is the big-endian 64-bit window starting at byte i of the byte sequence 00 00 E8 42 3C 0F 99 FF 00 00 E8 42 3C 0F 99. So enc_chk_o is 8'hC1 for data 64'h1 and 8'hC4 for data 64'h8000_0000_0000_0000.
- R2: The syndrome is the check byte computed from data_i XOR chk_i. A zero syndrome gives status_o = 0 (clean), with data_o = data_i and chk_o = chk_i.
- R3: A syndrome with exactly one bit k set is a check-byte error. chk_o is chk_i with bit k inverted, data_o = data_i, and status_o = 1 (corrected).
- R4: Data bits are numbered MSB-first, so error n lives in bit 63-n. The column of data error n is the 8-bit value whose bit i is bit 63-n of row i. A syndrome equal to that column inverts bit 63-n of data_i, leaves chk_o = chk_i and gives status_o = 1. Examples: 8'hC4 maps to 0, 8'h8C to 1, 8'h07 to 47, 8'hF4 to 4.
- R5: Every other nonzero syndrome gives status_o = 2 (uncorrectable), with data_o = data_i and chk_o = chk_i.
- R6: Any two distinct flipped bits in the 72-bit word {data, check} are reported with status_o = 2.
- R7: The encoder output enc_chk_o depends only on enc_data_i and is independent of the corrector inputs.
- R8: With PIPE = 1, data_o, chk_o and status_o appear one clock after their inputs. While rst_ni is low they read zero data, zero check byte and status 0. With PIPE = 0 they follow the inputs combinationally. status_o never reads 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_data_i | input | 64 | Data word for the encoder path |
| enc_chk_o | output | 8 | Check byte generated from enc_data_i |
| data_i | input | 64 | Received data word |
| chk_i | input | 8 | Received check byte |
| data_o | output | 64 | Corrected data word |
| chk_o | output | 8 | Corrected check byte |
| status_o | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |

## Verification
The bench builds the block with PIPE = 1. This puts the register stage, its one-cycle latency and its reset values within reach, while the corrector function stays the same as in the combinational variant.

With an all-zero data word the computed check byte is zero, so chk_i equals the syndrome. This lets the bench drive all 256 syndromes directly and compare them with a column model built from the rows.

The bench also flips every single bit of a 72-bit codeword. It then flips every one of the 2556 distinct bit pairs, which covers the full double-error space of one codeword.

// File: rtl/ecc72_pkg.sv
package ecc72_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int SEQ_W  = 8 * (DATA_W / 8 + CHK_W - 1);

  // rows are consecutive byte windows of this sequence
  localparam logic [SEQ_W-1:0] ROW_SEQ = 120'h0000E8423C0F99FF0000E8423C0F99;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_CORR    = 2'd1,
    ST_UNCORR  = 2'd2
  } ecc_status_e;

  function automatic logic [DATA_W-1:0] row_of(input int i);
    row_of = ROW_SEQ[SEQ_W-1-8*i -: DATA_W];
  endfunction

  // syndrome produced by a flip of word bit b (LSB numbering)
  function automatic logic [CHK_W-1:0] col_of(input int b);
    logic [DATA_W-1:0] r;
    col_of = '0;
    for (int i = 0; i < CHK_W; i++) begin
      r = row_of(i);
      col_of[i] = r[b];
    end
  endfunction
endpackage

// File: rtl/ecc72_encode.sv
module ecc72_encode
  import ecc72_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  for (genvar i = 0; i < CHK_W; i++) begin : g_row
    localparam logic [DATA_W-1:0] ROW = ROW_SEQ[SEQ_W-1-8*i -: DATA_W];
    assign chk_o[i] = ^(data_i & ROW);
  end
endmodule

// File: rtl/ecc72_syn_decode.sv
module ecc72_syn_decode
  import ecc72_pkg::*;
(
  input  logic [CHK_W-1:0]  syn_i,
  output logic [DATA_W-1:0] data_flip_o,
  output logic [CHK_W-1:0]  chk_flip_o,
  output ecc_status_e       status_o
);
  logic [DATA_W-1:0] hit;
  logic              single_chk;

  for (genvar b = 0; b < DATA_W; b++) begin : g_col
    localparam logic [CHK_W-1:0] COL = col_of(b);
    assign hit[b] = (syn_i == COL);
  end

  assign single_chk = (syn_i != '0) && ((syn_i & (syn_i - CHK_W'(1))) == '0);

  always_comb begin
    data_flip_o = '0;
    chk_flip_o  = '0;
    status_o    = ST_CLEAN;
    if (syn_i == '0) begin
      status_o = ST_CLEAN;
    end else if (single_chk) begin
      chk_flip_o = syn_i;
      status_o   = ST_CORR;
    end else if (|hit) begin
      data_flip_o = hit;
      status_o    = ST_CORR;
    end else begin
      status_o = ST_UNCORR;
    end
  end
endmodule

// File: rtl/ecc72_corrector.sv
module ecc72_corrector
  import ecc72_pkg::*;
#(
  parameter bit PIPE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CHK_W-1:0]  enc_chk_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  chk_o,
  output logic [1:0]        status_o
);
  logic [CHK_W-1:0]  rx_chk, syn, chk_flip, chk_c;
  logic [DATA_W-1:0] data_flip, data_c;
  ecc_status_e       st_c;

  ecc72_encode u_enc_tx (.data_i(enc_data_i), .chk_o(enc_chk_o));
  ecc72_encode u_enc_rx (.data_i(data_i),     .chk_o(rx_chk));

  assign syn = rx_chk ^ chk_i;

  ecc72_syn_decode u_dec (
    .syn_i       (syn),
    .data_flip_o (data_flip),
    .chk_flip_o  (chk_flip),
    .status_o    (st_c)
  );

  assign data_c = data_i ^ data_flip;
  assign chk_c  = chk_i ^ chk_flip;

  if (PIPE) begin : g_pipe
    logic [DATA_W-1:0] data_q;
    logic [CHK_W-1:0]  chk_q;
    logic [1:0]        st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        chk_q  <= '0;
        st_q   <= ST_CLEAN;
      end else begin
        data_q <= data_c;
        chk_q  <= chk_c;
        st_q   <= st_c;
      end
    end
    assign data_o   = data_q;
    assign chk_o    = chk_q;
    assign status_o = st_q;

    assert_pipe_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (status_o == $past(st_c) && data_o == $past(data_c) && chk_o == $past(chk_c)));
  end else begin : g_comb
    assign data_o   = data_c;
    assign chk_o    = chk_c;
    assign status_o = st_c;
  end

  assert_clean_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_c == ST_CLEAN) |-> (data_c == data_i && chk_c == chk_i && syn == '0));

  assert_one_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_c == ST_CORR) |-> ($countones({data_c ^ data_i, chk_c ^ chk_i}) == 1));

  assert_flip_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(data_flip) && ((data_flip == '0) || (chk_flip == '0)));

  assert_ue_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_c == ST_UNCORR) |-> (data_c == data_i && chk_c == chk_i));

  assert_status_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'd3);
endmodule

// File: tb/ecc72_corrector_bench.sv
`timescale 1ns/1ps
module ecc72_corrector_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] enc_data_i = '0;
  logic [7:0]  enc_chk_o;
  logic [63:0] data_i = '0;
  logic [7:0]  chk_i = '0;
  logic [63:0] data_o;
  logic [7:0]  chk_o;
  logic [1:0]  status_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ecc72_corrector #(.PIPE(1'b1)) u_ecc72_corrector (
    .clk_i(clk), .rst_ni(rst_ni),
    .enc_data_i(enc_data_i), .enc_chk_o(enc_chk_o),
    .data_i(data_i), .chk_i(chk_i),
    .data_o(data_o), .chk_o(chk_o), .status_o(status_o)
  );

  localparam logic [7:0] SEQ [0:14] = '{8'h00, 8'h00, 8'hE8, 8'h42, 8'h3C, 8'h0F, 8'h99,
                                        8'hFF, 8'h00, 8'h00, 8'hE8, 8'h42, 8'h3C, 8'h0F, 8'h99};

  function automatic logic [63:0] m_row(input int i);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) r = {r[55:0], SEQ[i+k]};
    return r;
  endfunction

  function automatic logic [7:0] m_enc(input logic [63:0] d);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) c[i] = ^(d & m_row(i));
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [73:0] act, input logic [73:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample after the register edge
  task automatic apply(input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    data_i = d;
    chk_i = c;
    enc_data_i = d;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [1:0] st, input logic [63:0] d, input logic [7:0] c);
    check({status_o, data_o, chk_o} === {st, d, c}, req, {status_o, data_o, chk_o}, {st, d, c});
  endtask

  initial begin
    logic [63:0] d;
    logic [7:0]  c;
    logic [71:0] w;
    repeat (3) @(negedge clk);
    // R8 reset values
    expect_out("R8 reset", 2'd0, 64'h0, 8'h0);
    rst_ni = 1'b1;

    // R1 encoder literals and walking ones
    apply(64'h1, 8'h00);
    check(enc_chk_o === 8'hC1, "R1 enc lsb", {66'h0, enc_chk_o}, 74'hC1);
    apply(64'h8000_0000_0000_0000, 8'h00);
    check(enc_chk_o === 8'hC4, "R1 enc msb", {66'h0, enc_chk_o}, 74'hC4);
    apply('1, 8'h00);
    check(enc_chk_o === 8'h00, "R1 enc ones", {66'h0, enc_chk_o}, 74'h0);
    for (int b = 0; b < 64; b++) begin
      apply(64'h1 << b, 8'h00);
      check(enc_chk_o === m_enc(64'h1 << b), "R1 enc walk", {66'h0, enc_chk_o}, {66'h0, m_enc(64'h1 << b)});
    end

    // R2 clean words; R7 encoder follows its own input only
    for (int k = 0; k < 32; k++) begin
      d = (64'h0123_4567_89AB_CDEF * 64'(k + 1)) ^ {32'(k) * 32'h9E37_79B9, 32'hA5A5_0000 | 32'(k)};
      apply(d, m_enc(d));
      expect_out("R2 clean", 2'd0, d, m_enc(d));
    end
    @(negedge clk);
    enc_data_i = 64'h1;
    data_i = 64'hFFFF_0000_FFFF_0000;
    chk_i = 8'h5A;
    #1;
    check(enc_chk_o === 8'hC1, "R7 enc independent", {66'h0, enc_chk_o}, 74'hC1);

    // R3 R4 R5 sweep of all syndromes with zero data
    for (int s = 0; s < 256; s++) begin
      logic [1:0]  est;
      logic [63:0] ed;
      est = 2'd2;
      ed = '0;
      if (s == 0) est = 2'd0;
      else if ($countones(s[7:0]) == 1) est = 2'd1;
      else
        for (int n = 0; n < 64; n++)
          if (m_enc(64'h1 << (63 - n)) == s[7:0]) begin
            est = 2'd1;
            ed = 64'h1 << (63 - n);
          end
      apply(64'h0, s[7:0]);
      if ($countones(s[7:0]) == 1)
        expect_out("R3 chk syndrome", est, ed, 8'h00);
      else if (est == 2'd1)
        expect_out("R4 data syndrome", est, ed, s[7:0]);
      else
        expect_out("R5 other syndrome", est, ed, s[7:0]);
    end

    // R4 listed mappings: syndrome -> MSB-first bit number
    apply(64'h0, 8'hC4); expect_out("R4 C4->0", 2'd1, 64'h1 << 63, 8'hC4);
    apply(64'h0, 8'h8C); expect_out("R4 8C->1", 2'd1, 64'h1 << 62, 8'h8C);
    apply(64'h0, 8'hF4); expect_out("R4 F4->4", 2'd1, 64'h1 << 59, 8'hF4);
    apply(64'h0, 8'h07); expect_out("R4 07->47", 2'd1, 64'h1 << 16, 8'h07);
    apply(64'h0, 8'h0B); expect_out("R4 0B->37", 2'd1, 64'h1 << 26, 8'h0B);
    apply(64'h0, 8'h15); expect_out("R4 15->30", 2'd1, 64'h1 << 33, 8'h15);

    // R4 / R3 single flips on a nonzero codeword
    d = 64'hDEAD_BEEF_0BAD_F00D;
    c = m_enc(d);
    for (int b = 0; b < 64; b++) begin
      apply(d ^ (64'h1 << b), c);
      expect_out("R4 data flip", 2'd1, d, c);
    end
    for (int b = 0; b < 8; b++) begin
      apply(d, c ^ (8'h1 << b));
      expect_out("R3 chk flip", 2'd1, d, c);
    end

    // R6 all double errors in the 72-bit word
    for (int i = 0; i < 72; i++)
      for (int j = i + 1; j < 72; j++) begin
        w = {d, c} ^ (72'h1 << i) ^ (72'h1 << j);
        apply(w[71:8], w[7:0]);
        expect_out("R6 double", 2'd2, w[71:8], w[7:0]);
      end

    // R8 one-cycle latency: old value holds until the edge
    apply(d, c);
    @(negedge clk);
    data_i = 64'h0;
    chk_i = 8'h03;
    #1;
    expect_out("R8 hold before edge", 2'd0, d, c);
    @(posedge clk);
    #1;
    expect_out("R8 after edge", 2'd2, 64'h0, 8'h03);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule